// File: doc/BRIEF.md
# Bounded Response Monitor

This block watches two single-bit signals on a chip, a trigger and a response, and checks a timing rule between them. Time is counted in clock cycles. When the trigger rises, an obligation opens and a cycle counter starts. The obligation closes as soon as the response is high. The block judges the rule while the obligation is open and at the moment it closes.

A static mode input picks the direction of the bound. In late mode the response must come before the counter passes the bound. In early mode the response must not come before the counter has reached the bound. Any breach raises an error flag, and the flag stays high until reset. The open obligation and the running count are visible as outputs, so surrounding logic or a bench can follow the timing directly.

Only one obligation is tracked at a time. A trigger that rises while an obligation is open is ignored.

Top module: `brc_monitor`

## Requirements
- R1: After reset, with `rst_n` low, `pending_o`, `elapsed_o` and `error_o` are all 0.
- R2: A trigger rise is a cycle with `trig_i`=1 where `trig_i` was 0 in the previous cycle. A rise while `pending_o`=0 and `resp_i`=0 gives `pending_o`=1 and `elapsed_o`=0 in the next cycle.
- R3: `resp_i`=1 in a cycle with `pending_o`=1 gives `pending_o`=0 in the next cycle. `elapsed_o` then keeps its last value until the next accepted trigger.
- R4: Late mode is `mode_min_i`=0. In this mode, `error_o` is 1 in every cycle where `pending_o`=1 and `elapsed_o` > `bound_i`.
- R5: In each cycle with `pending_o`=1 and `resp_i`=0, `elapsed_o` grows by one in the next cycle. It stops at 2^CNT_W-1 and does not wrap.
- R6: A trigger rise while `pending_o`=1 does not restart the count. A trigger held high does not open a second obligation.
- R7: Early mode is `mode_min_i`=1. In this mode, `resp_i`=1 in a cycle with `pending_o`=1 and `elapsed_o` < `bound_i` makes `error_o` 1 in that same cycle.
- R8: A trigger rise with `resp_i`=1 in the same cycle counts as a response at elapsed 0. `pending_o` stays 0 and `elapsed_o` becomes 0. In early mode this is an error exactly when `bound_i` > 0.
- R9: `error_o` rises in the cycle the breach is detected and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_min_i | input | 1 | Static mode: 0 late bound, 1 early bound |
| bound_i | input | BOUND_W | Bound T in cycles, unsigned |
| trig_i | input | 1 | Trigger signal |
| resp_i | input | 1 | Response signal |
| pending_o | output | 1 | An obligation is open |
| elapsed_o | output | CNT_W | Cycles counted since the obligation opened |
| error_o | output | 1 | Sticky breach flag |

## Verification
The assertions check on every cycle how the obligation opens and closes, how the counter steps and saturates, how a trigger rise during an open obligation leaves the count untouched, how both bound comparisons and the same-cycle case raise the error, and that the error stays set. Only the bench scenarios can show full sequences end to end. These include the exact cycle in which a late breach first appears, the count frozen after a response, saturation at the top of a short counter, a trigger held high across a response, and the early-mode split between a zero and a non-zero bound in the same-cycle case.

// File: rtl/brc_pkg.sv
package brc_pkg;

  // Direction of the bound being enforced
  typedef enum logic {
    BRC_LATE  = 1'b0,  // response must not come after the bound
    BRC_EARLY = 1'b1   // response must not come before the bound
  } brc_mode_e;

  // Arguments are zero-extended to 32 bits by the caller (CNT_W, BOUND_W <= 32)
  function automatic logic late_breach(input int unsigned el, input int unsigned lim);
    return el > lim;
  endfunction

  function automatic logic early_breach(input int unsigned el, input int unsigned lim);
    return el < lim;
  endfunction

endpackage

// File: rtl/brc_rise.sv
// Rising-edge detect against a registered copy of the input
module brc_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/brc_timer.sv
// Single-obligation tracker: pending flag plus saturating elapsed count
module brc_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             resp_i,
  output logic             pending_o,
  output logic [CNT_W-1:0] elapsed_o,
  output logic             accept_o,
  output logic             met_o,
  output logic [CNT_W-1:0] met_el_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] step_sat(input logic [CNT_W-1:0] v);
    return (v == CNT_TOP) ? v : v + CNT_W'(1);
  endfunction

  logic             pend_q;
  logic [CNT_W-1:0] el_q;

  // A start is taken only when nothing is outstanding
  assign accept_o = start_i & ~pend_q;
  // Obligation discharged this cycle, either open or opened-and-closed at once
  assign met_o    = resp_i & (pend_q | accept_o);
  assign met_el_o = pend_q ? el_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      el_q   <= '0;
    end else if (accept_o) begin
      el_q   <= '0;
      pend_q <= ~resp_i;
    end else if (pend_q) begin
      if (resp_i) pend_q <= 1'b0;
      else        el_q   <= step_sat(el_q);
    end
  end

  assign pending_o = pend_q;
  assign elapsed_o = el_q;

endmodule

// File: rtl/brc_judge.sv
// Bound comparison and sticky error
module brc_judge
  import brc_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int BOUND_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  brc_mode_e          mode_i,
  input  logic               pending_i,
  input  logic [CNT_W-1:0]   elapsed_i,
  input  logic               met_i,
  input  logic [CNT_W-1:0]   met_el_i,
  input  logic [BOUND_W-1:0] bound_i,
  output logic               viol_o,
  output logic               error_o
);

  logic err_q;

  always_comb begin
    unique case (mode_i)
      BRC_LATE:  viol_o = pending_i & late_breach(32'(elapsed_i), 32'(bound_i));
      BRC_EARLY: viol_o = met_i & early_breach(32'(met_el_i), 32'(bound_i));
      default:   viol_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (viol_o) err_q <= 1'b1;
  end

  assign error_o = err_q | viol_o;

endmodule

// File: rtl/brc_monitor.sv
module brc_monitor
  import brc_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int BOUND_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_min_i,
  input  logic [BOUND_W-1:0] bound_i,
  input  logic               trig_i,
  input  logic               resp_i,
  output logic               pending_o,
  output logic [CNT_W-1:0]   elapsed_o,
  output logic               error_o
);

  // Named internal events, visible to the bound checker
  logic             trig_rise;
  logic             accept;
  logic             met_now;
  logic [CNT_W-1:0] met_el;
  logic             viol_now;

  brc_rise u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (trig_i),
    .rise_o (trig_rise)
  );

  brc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (trig_rise),
    .resp_i    (resp_i),
    .pending_o (pending_o),
    .elapsed_o (elapsed_o),
    .accept_o  (accept),
    .met_o     (met_now),
    .met_el_o  (met_el)
  );

  brc_judge #(.CNT_W(CNT_W), .BOUND_W(BOUND_W)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (brc_mode_e'(mode_min_i)),
    .pending_i (pending_o),
    .elapsed_i (elapsed_o),
    .met_i     (met_now),
    .met_el_i  (met_el),
    .bound_i   (bound_i),
    .viol_o    (viol_now),
    .error_o   (error_o)
  );

endmodule

// File: rtl/brc_monitor_chk.sv
module brc_monitor_chk #(
  parameter int CNT_W   = 8,
  parameter int BOUND_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_min_i,
  input logic [BOUND_W-1:0] bound_i,
  input logic               trig_i,
  input logic               resp_i,
  input logic               pending_o,
  input logic [CNT_W-1:0]   elapsed_o,
  input logic               error_o,
  input logic               trig_rise,
  input logic               accept,
  input logic               met_now,
  input logic               viol_now
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R2: accepted trigger with response low opens an obligation at zero
  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && trig_i && !resp_i) |=> (pending_o && elapsed_o == '0));

  // R3: response closes the obligation
  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (met_now && pending_o) |=> !pending_o);

  // R3: count frozen after close
  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_o && !trig_rise) |=> $stable(elapsed_o));

  // R4: late breach shows on the error output
  assert_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_min_i && pending_o && 32'(elapsed_o) > 32'(bound_i)) |-> error_o);

  // R5: count steps by one while waiting
  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !resp_i && elapsed_o != TOP) |=> (elapsed_o == $past(elapsed_o) + CNT_W'(1)));

  // R5: count saturates
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !resp_i && elapsed_o == TOP) |=> (elapsed_o == TOP));

  // R6: a trigger rise while pending does not clear the count
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && trig_rise && !resp_i && elapsed_o != TOP) |=> (pending_o && elapsed_o != '0));

  // R7: early response is an error
  assert_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_min_i && pending_o && resp_i && 32'(elapsed_o) < 32'(bound_i)) |-> error_o);

  // R8: same-cycle response closes at zero without pending
  assert_instant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rise && !pending_o && resp_i) |=> (!pending_o && elapsed_o == '0));

  // R8: same-cycle response in early mode with non-zero bound
  assert_instant_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_min_i && trig_rise && !pending_o && resp_i && bound_i != '0) |-> error_o);

  // R9: a detected breach is held
  assert_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_now |=> error_o);

  // R9: error is sticky
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> error_o);

endmodule

bind brc_monitor brc_monitor_chk #(.CNT_W(CNT_W), .BOUND_W(BOUND_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_min_i (mode_min_i),
  .bound_i    (bound_i),
  .trig_i     (trig_i),
  .resp_i     (resp_i),
  .pending_o  (pending_o),
  .elapsed_o  (elapsed_o),
  .error_o    (error_o),
  .trig_rise  (trig_rise),
  .accept     (accept),
  .met_now    (met_now),
  .viol_now   (viol_now)
);

// File: tb/brc_monitor_tb.sv
module brc_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CW  = 4;
  localparam int BW  = 4;
  localparam int TOP = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_min = 1'b0;
  logic [BW-1:0] bound = '0;
  logic          trig = 1'b0;
  logic          resp = 1'b0;
  logic          pending;
  logic [CW-1:0] elapsed;
  logic          error;

  int vectors = 0;
  int miscompares = 0;

  // Scoreboard queues: {pending, elapsed, error} and tag
  logic [CW+1:0] exp_q[$];
  string         tag_q[$];

  // Reference state, kept as time stamps rather than a counter
  int  stp;
  int  m_arm;
  int  m_frozen;
  bit  m_pend;
  bit  m_err;
  bit  m_tp;

  always #(CLK_PERIOD/2) clk = ~clk;

  brc_monitor #(.CNT_W(CW), .BOUND_W(BW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_min_i (mode_min),
    .bound_i    (bound),
    .trig_i     (trig),
    .resp_i     (resp),
    .pending_o  (pending),
    .elapsed_o  (elapsed),
    .error_o    (error)
  );

  task automatic model_clear();
    stp = 0; m_arm = 0; m_frozen = 0; m_pend = 0; m_err = 0; m_tp = 0;
  endtask

  // Reset, set the static mode and bound, and check R1 during reset
  task automatic restart(input bit mode, input int lim);
    @(negedge clk);
    rst_n = 1'b0; trig = 1'b0; resp = 1'b0;
    mode_min = mode; bound = BW'(lim);
    @(negedge clk);
    @(negedge clk);
    #1;
    vectors++;
    if (pending !== 1'b0 || elapsed !== '0 || error !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset state: got p=%0b e=%0d err=%0b expected p=0 e=0 err=0",
               pending, elapsed, error);
    end
    rst_n = 1'b1;
    model_clear();
  endtask

  // Driver: apply one cycle of inputs and push what the outputs must show
  task automatic step(input bit t, input bit r, input string tag);
    int  e_cur;
    bit  rise;
    bit  viol;
    @(negedge clk);
    trig = t; resp = r;
    rise  = t && !m_tp;
    e_cur = m_pend ? (((stp - m_arm) > TOP) ? TOP : (stp - m_arm)) : m_frozen;
    viol  = 0;
    if (!mode_min) begin
      if (m_pend && e_cur > int'(bound)) viol = 1;
    end else begin
      if (m_pend && r && e_cur < int'(bound)) viol = 1;
      if (!m_pend && rise && r && int'(bound) > 0) viol = 1;
    end
    exp_q.push_back({m_pend, CW'(e_cur), m_err | viol});
    tag_q.push_back(tag);
    m_err = m_err | viol;
    if (!m_pend && rise) begin
      if (r) m_frozen = 0;
      else begin m_pend = 1; m_arm = stp + 1; end
    end else if (m_pend && r) begin
      m_frozen = e_cur;
      m_pend = 0;
    end
    m_tp = t;
    stp++;
  endtask

  // Monitor: pop and compare shortly after the inputs settle
  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [CW+1:0] ex;
      string tg;
      ex = exp_q.pop_front();
      tg = tag_q.pop_front();
      vectors++;
      if ({pending, elapsed, error} !== ex) begin
        miscompares++;
        $display("FAIL %s: got p=%0b e=%0d err=%0b expected p=%0b e=%0d err=%0b",
                 tg, pending, elapsed, error, ex[CW+1], ex[CW:1], ex[0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // Late mode, bound 3
    restart(1'b0, 3);
    step(0, 0, "R1 idle");
    step(0, 0, "R1 idle");
    step(1, 0, "R2 trigger");
    step(0, 0, "R2 opened at zero");
    step(0, 0, "R5 counting");
    step(0, 1, "R3 response");
    for (int i = 0; i < 3; i++) step(0, 0, "R3 frozen count");
    // Retrigger pulse while pending
    step(1, 0, "R2 trigger again");
    step(0, 0, "R6 pending");
    step(1, 0, "R6 rise while pending");
    step(0, 0, "R6 count kept");
    step(0, 1, "R3 close");
    // Late breach
    step(1, 0, "R4 trigger");
    for (int i = 0; i < 6; i++) step(0, 0, "R4 waiting past bound");
    step(0, 1, "R9 response after breach");
    for (int i = 0; i < 3; i++) step(0, 0, "R9 error held");

    // Saturation: bound at counter top, never late
    restart(1'b0, TOP);
    step(1, 0, "R5 trigger");
    for (int i = 0; i < 20; i++) step(0, 0, "R5 saturate");
    step(0, 1, "R5 close at top");
    step(0, 0, "R3 frozen at top");

    // Trigger held high across a response
    restart(1'b0, 7);
    step(1, 0, "R2 held trigger");
    step(1, 0, "R6 held");
    step(1, 1, "R3 close while held");
    for (int i = 0; i < 4; i++) step(1, 0, "R6 no rearm while held");
    step(0, 0, "R6 release");

    // Early mode, bound 3
    restart(1'b1, 3);
    step(1, 0, "R7 trigger");
    step(0, 0, "R7 wait");
    step(0, 0, "R7 wait");
    step(0, 0, "R7 wait");
    step(0, 1, "R7 response on bound");
    step(0, 0, "R7 no error");
    step(1, 1, "R8 same-cycle response, bound 3");
    step(0, 0, "R9 error held");
    step(0, 0, "R9 error held");

    // Early mode, bound 0: same-cycle response allowed
    restart(1'b1, 0);
    step(1, 1, "R8 same-cycle response, bound 0");
    step(0, 0, "R8 stays idle");

    // Early mode, bound 4: response too soon
    restart(1'b1, 4);
    step(1, 0, "R7 trigger");
    step(0, 0, "R7 wait");
    step(0, 1, "R7 early response");
    step(0, 0, "R9 error held");

    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule